// File: doc/BRIEF.md
# Set lookup with counter LRU

This block makes the tag lookup and replacement decision for one cache bank. The bank scheduler presents one request per cycle. The request carries a set index, a tag, a write flag, a replay flag and a group of merged requester slots; each slot has a valid bit, a requester id and a requester tag. The block keeps the tag-side state of the bank: per way a valid bit, a dirty bit, a tag and a small age counter. It compares the request tag against every way of the addressed set, ages the set, and chooses one action. The action is a response to the requesters, a write forwarded to memory, a dirty-victim writeback, or a miss-status allocation with a fill request.

Every result is registered, so each output appears one cycle after its request. The miss-status lookup is combinational on the request cycle: the bank's miss table reports whether a fill for the same line is already in flight, and which entry id it would hand out. Data arrays and the return path of fills are outside this block. The only part of fill return that is visible here is a narrow install port that writes a way's tag.

Top module: `set_lookup_lru`

## Requirements
- R1: After reset every way of every set is invalid and every output valid flag is low.
- R2: A lookup clears the age counter of the way that hits. It increments the counter of every other valid way, and a counter stops at its maximum value instead of wrapping.
- R3: On a miss the victim is the highest-numbered invalid way when one exists. Otherwise it is the lowest-numbered way whose age, after the update, is the largest.
- R4: A read hit raises the response valid of exactly the request's valid slots, with their ids and tags, and makes no memory or miss-status request.
- R5: In write-back mode, a miss that finds no free way and a dirty victim issues a writeback at the victim's line address alongside the allocation.
- R6: In write-back mode a write hit marks the way dirty and sends nothing to memory. It responds to the valid slots only when write responses are enabled.
- R7: Any read miss, and any write miss in write-back mode, allocates a miss-status entry for the victim way. A fill request (write flag equal to the request's, tag equal to the offered entry id) is sent only when no in-flight entry already covers the line.
- R8: A replay request skips the lookup. It responds to all of its valid slots, leaves the ages unchanged and makes no memory or allocation request.
- R9: In write-through mode every write is forwarded to memory with tag 0 and never allocates. Its response is sent only when write responses are enabled.
- R10: Every memory address is the concatenation, from the top down, of the line tag, the set index, the bank index and zeroed offset bits.
- R11: An install validates a way with the given tag, clears its dirty bit and sets its age to zero.
- R12: Every output appears on the cycle after its request, and a cycle with no request yields no valid output on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_replay | input | 1 | Request is a miss-status replay |
| req_write | input | 1 | Request is a write |
| req_set | input | SET_W | Set index |
| req_tag | input | TAG_W | Line tag |
| req_slot_valid | input | PORTS | Valid bit per merged slot |
| req_slot_id | input | PORTS*REQID_W | Requester id per slot, slot 0 in the low bits |
| req_slot_tag | input | PORTS*RTAG_W | Requester tag per slot, slot 0 in the low bits |
| inst_valid | input | 1 | Install a tag into a way |
| inst_set | input | SET_W | Install set |
| inst_way | input | WAY_W | Install way |
| inst_tag | input | TAG_W | Installed tag |
| mshr_pending | input | 1 | A miss-status entry already covers the request line |
| mshr_alloc_id | input | MSHR_ID_W | Entry id offered for an allocation |
| rsp_valid | output | PORTS | Response valid per slot |
| rsp_id | output | PORTS*REQID_W | Response requester ids |
| rsp_tag | output | PORTS*RTAG_W | Response requester tags |
| mem_req_valid | output | 1 | Fill or forwarded write request |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | ADDR_W | Memory request line address |
| mem_req_tag | output | MSHR_ID_W | Entry id for fills, 0 for forwarded writes |
| wb_valid | output | 1 | Dirty victim writeback |
| wb_addr | output | ADDR_W | Writeback line address |
| mshr_alloc_valid | output | 1 | Allocate a miss-status entry |
| mshr_alloc_set | output | SET_W | Allocated set |
| mshr_alloc_tag | output | TAG_W | Allocated tag |
| mshr_alloc_way | output | WAY_W | Victim way reserved for the fill |
| mshr_alloc_write | output | 1 | Allocated request is a write |

## Verification
The checks take for granted that tags within a set are unique, so that at most one way matches. They also assume that `mshr_pending` and `mshr_alloc_id` are valid in the same cycle as the request, and that the `mshr_pending` answer describes the line being looked up. The stimulus installs distinct tags into each set and drives the miss-status inputs together with every request. A write-back instance and a write-through instance with write responses disabled share the inputs. Each scenario targets sets that no other scenario touches, so the expected age state can be traced by hand.

// File: rtl/set_lookup_lru_pkg.sv
package set_lookup_lru_pkg;

    // Action flags produced by the outcome decoder for one lookup.
    typedef struct packed {
        logic respond;     // answer the valid slots
        logic fwd_write;   // write sent straight to memory
        logic writeback;   // dirty victim goes to memory
        logic allocate;    // reserve a miss-status entry
        logic fill;        // line request to memory
        logic mark_dirty;  // hit way becomes dirty
        logic age_update;  // set ages are rewritten
    } lookup_plan_t;

    localparam lookup_plan_t PLAN_NONE = '0;

endpackage

// File: rtl/sll_tag_store.sv
module sll_tag_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 8,
    parameter int TAG_W = 8,
    parameter int AGE_W = 2,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [SET_W-1:0]                rd_set,
    output logic [WAYS-1:0]                 rd_valid,
    output logic [WAYS-1:0]                 rd_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]      rd_tag,
    output logic [WAYS-1:0][AGE_W-1:0]      rd_age,
    input  logic                            upd_en,
    input  logic [SET_W-1:0]                upd_set,
    input  logic [WAYS-1:0][AGE_W-1:0]      upd_age,
    input  logic                            dirty_en,
    input  logic [WAY_W-1:0]                dirty_way,
    input  logic                            inst_en,
    input  logic [SET_W-1:0]                inst_set,
    input  logic [WAY_W-1:0]                inst_way,
    input  logic [TAG_W-1:0]                inst_tag
);

    logic [SETS-1:0][WAYS-1:0]             valid_q;
    logic [SETS-1:0][WAYS-1:0]             dirty_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
    logic [SETS-1:0][WAYS-1:0][AGE_W-1:0]  age_q;

    assign rd_valid = valid_q[rd_set];
    assign rd_dirty = dirty_q[rd_set];
    assign rd_tag   = tag_q[rd_set];
    assign rd_age   = age_q[rd_set];

    // Install is applied last so it wins over a lookup update of the same way.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
            tag_q   <= '0;
            age_q   <= '0;
        end else begin
            if (upd_en) begin
                age_q[upd_set] <= upd_age;
            end
            if (dirty_en) begin
                dirty_q[upd_set][dirty_way] <= 1'b1;
            end
            if (inst_en) begin
                valid_q[inst_set][inst_way] <= 1'b1;
                dirty_q[inst_set][inst_way] <= 1'b0;
                tag_q[inst_set][inst_way]   <= inst_tag;
                age_q[inst_set][inst_way]   <= '0;
            end
        end
    end

endmodule

// File: rtl/sll_way_eval.sv
module sll_way_eval #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    parameter int AGE_W = 2,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [WAYS-1:0][AGE_W-1:0]  way_age,
    input  logic [TAG_W-1:0]            look_tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic                        any_free,
    output logic [WAY_W-1:0]            victim_way,
    output logic [WAYS-1:0][AGE_W-1:0]  next_age
);

    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    logic [WAYS-1:0]    match;
    logic [WAY_W-1:0]   free_way;
    logic [WAY_W-1:0]   oldest_way;
    logic [AGE_W-1:0]   oldest_age;

    // Per-way compare and saturating age step.
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign match[g] = way_valid[g] && (way_tag[g] == look_tag);
        always_comb begin
            if (match[g]) begin
                next_age[g] = '0;
            end else if (way_valid[g] && (way_age[g] != AGE_MAX)) begin
                next_age[g] = way_age[g] + 1'b1;
            end else begin
                next_age[g] = way_age[g];
            end
        end
    end

    always_comb begin
        hit        = 1'b0;
        hit_way    = '0;
        any_free   = 1'b0;
        free_way   = '0;
        oldest_age = '0;
        oldest_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
            if (!way_valid[w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end else if (next_age[w] > oldest_age) begin
                oldest_age = next_age[w];
                oldest_way = WAY_W'(w);
            end
        end
        victim_way = any_free ? free_way : oldest_way;
    end

endmodule

// File: rtl/sll_action.sv
module sll_action
    import set_lookup_lru_pkg::*;
#(
    parameter bit WRITE_THROUGH = 1'b0,
    parameter bit WRITE_RSP     = 1'b1
) (
    input  logic         req_valid,
    input  logic         req_replay,
    input  logic         req_write,
    input  logic         hit,
    input  logic         any_free,
    input  logic         victim_dirty,
    input  logic         mshr_pending,
    output lookup_plan_t plan
);

    always_comb begin
        plan = PLAN_NONE;
        if (req_valid) begin
            if (req_replay) begin
                plan.respond = 1'b1;
            end else begin
                plan.age_update = 1'b1;
                if (hit) begin
                    if (req_write) begin
                        plan.fwd_write  = WRITE_THROUGH;
                        plan.mark_dirty = !WRITE_THROUGH;
                    end
                    plan.respond = !req_write || WRITE_RSP;
                end else if (req_write && WRITE_THROUGH) begin
                    plan.fwd_write = 1'b1;
                    plan.respond   = WRITE_RSP;
                end else begin
                    plan.allocate  = 1'b1;
                    plan.fill      = !mshr_pending;
                    plan.writeback = !WRITE_THROUGH && !any_free && victim_dirty;
                end
            end
        end
    end

endmodule

// File: rtl/set_lookup_lru.sv
module set_lookup_lru
    import set_lookup_lru_pkg::*;
#(
    parameter int WAYS          = 4,
    parameter int SETS          = 8,
    parameter int TAG_W         = 8,
    parameter int AGE_W         = 2,
    parameter int BANK_W        = 1,
    parameter int BANK_ID       = 1,
    parameter int OFFSET_W      = 4,
    parameter int PORTS         = 2,
    parameter int REQID_W       = 2,
    parameter int RTAG_W        = 4,
    parameter int MSHR_ID_W     = 2,
    parameter bit WRITE_THROUGH = 1'b0,
    parameter bit WRITE_RSP     = 1'b1,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int ADDR_W = TAG_W + SET_W + BANK_W + OFFSET_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic                       req_replay,
    input  logic                       req_write,
    input  logic [SET_W-1:0]           req_set,
    input  logic [TAG_W-1:0]           req_tag,
    input  logic [PORTS-1:0]           req_slot_valid,
    input  logic [PORTS*REQID_W-1:0]   req_slot_id,
    input  logic [PORTS*RTAG_W-1:0]    req_slot_tag,
    input  logic                       inst_valid,
    input  logic [SET_W-1:0]           inst_set,
    input  logic [WAY_W-1:0]           inst_way,
    input  logic [TAG_W-1:0]           inst_tag,
    input  logic                       mshr_pending,
    input  logic [MSHR_ID_W-1:0]       mshr_alloc_id,
    output logic [PORTS-1:0]           rsp_valid,
    output logic [PORTS*REQID_W-1:0]   rsp_id,
    output logic [PORTS*RTAG_W-1:0]    rsp_tag,
    output logic                       mem_req_valid,
    output logic                       mem_req_write,
    output logic [ADDR_W-1:0]          mem_req_addr,
    output logic [MSHR_ID_W-1:0]       mem_req_tag,
    output logic                       wb_valid,
    output logic [ADDR_W-1:0]          wb_addr,
    output logic                       mshr_alloc_valid,
    output logic [SET_W-1:0]           mshr_alloc_set,
    output logic [TAG_W-1:0]           mshr_alloc_tag,
    output logic [WAY_W-1:0]           mshr_alloc_way,
    output logic                       mshr_alloc_write
);

    function automatic logic [ADDR_W-1:0] line_addr(input logic [TAG_W-1:0] t,
                                                    input logic [SET_W-1:0] s);
        return {t, s, BANK_W'(BANK_ID), {OFFSET_W{1'b0}}};
    endfunction

    logic [WAYS-1:0]             way_valid;
    logic [WAYS-1:0]             way_dirty;
    logic [WAYS-1:0][TAG_W-1:0]  way_tag;
    logic [WAYS-1:0][AGE_W-1:0]  way_age;
    logic [WAYS-1:0][AGE_W-1:0]  next_age;
    logic                        hit;
    logic [WAY_W-1:0]            hit_way;
    logic                        any_free;
    logic [WAY_W-1:0]            victim_way;
    lookup_plan_t                plan;

    sll_tag_store #(
        .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .AGE_W(AGE_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_set   (req_set),
        .rd_valid (way_valid),
        .rd_dirty (way_dirty),
        .rd_tag   (way_tag),
        .rd_age   (way_age),
        .upd_en   (plan.age_update),
        .upd_set  (req_set),
        .upd_age  (next_age),
        .dirty_en (plan.mark_dirty),
        .dirty_way(hit_way),
        .inst_en  (inst_valid),
        .inst_set (inst_set),
        .inst_way (inst_way),
        .inst_tag (inst_tag)
    );

    sll_way_eval #(
        .WAYS(WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W)
    ) u_eval (
        .way_valid (way_valid),
        .way_tag   (way_tag),
        .way_age   (way_age),
        .look_tag  (req_tag),
        .hit       (hit),
        .hit_way   (hit_way),
        .any_free  (any_free),
        .victim_way(victim_way),
        .next_age  (next_age)
    );

    sll_action #(
        .WRITE_THROUGH(WRITE_THROUGH), .WRITE_RSP(WRITE_RSP)
    ) u_action (
        .req_valid   (req_valid),
        .req_replay  (req_replay),
        .req_write   (req_write),
        .hit         (hit),
        .any_free    (any_free),
        .victim_dirty(way_dirty[victim_way]),
        .mshr_pending(mshr_pending),
        .plan        (plan)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid        <= '0;
            rsp_id           <= '0;
            rsp_tag          <= '0;
            mem_req_valid    <= 1'b0;
            mem_req_write    <= 1'b0;
            mem_req_addr     <= '0;
            mem_req_tag      <= '0;
            wb_valid         <= 1'b0;
            wb_addr          <= '0;
            mshr_alloc_valid <= 1'b0;
            mshr_alloc_set   <= '0;
            mshr_alloc_tag   <= '0;
            mshr_alloc_way   <= '0;
            mshr_alloc_write <= 1'b0;
        end else begin
            rsp_valid        <= plan.respond ? req_slot_valid : '0;
            rsp_id           <= req_slot_id;
            rsp_tag          <= req_slot_tag;
            mem_req_valid    <= plan.fwd_write || plan.fill;
            mem_req_write    <= plan.fwd_write || req_write;
            mem_req_addr     <= line_addr(req_tag, req_set);
            mem_req_tag      <= plan.fill ? mshr_alloc_id : '0;
            wb_valid         <= plan.writeback;
            wb_addr          <= line_addr(way_tag[victim_way], req_set);
            mshr_alloc_valid <= plan.allocate;
            mshr_alloc_set   <= req_set;
            mshr_alloc_tag   <= req_tag;
            mshr_alloc_way   <= victim_way;
            mshr_alloc_write <= req_write;
        end
    end

endmodule

// File: rtl/set_lookup_lru_chk.sv
module set_lookup_lru_chk #(
    parameter int PORTS     = 2,
    parameter int TAG_W     = 8,
    parameter int ADDR_W    = 16,
    parameter int MSHR_ID_W = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_replay,
    input logic [TAG_W-1:0]     req_tag,
    input logic [PORTS-1:0]     req_slot_valid,
    input logic                 mshr_pending,
    input logic [MSHR_ID_W-1:0] mshr_alloc_id,
    input logic [PORTS-1:0]     rsp_valid,
    input logic                 mem_req_valid,
    input logic [ADDR_W-1:0]    mem_req_addr,
    input logic [MSHR_ID_W-1:0] mem_req_tag,
    input logic                 wb_valid,
    input logic                 mshr_alloc_valid
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (rsp_valid == '0 && !mem_req_valid && !wb_valid && !mshr_alloc_valid)); // R12

    AST_RSP_IN_SLOTS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ((rsp_valid & ~$past(req_slot_valid)) == '0)); // R4

    AST_REPLAY_ONLY_RSP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_replay) |=> (!mem_req_valid && !wb_valid && !mshr_alloc_valid
                                       && rsp_valid == $past(req_slot_valid))); // R8

    AST_FILL_CARRIES_ID: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_replay && !mshr_pending) |=>
            (!mshr_alloc_valid || (mem_req_valid && mem_req_tag == $past(mshr_alloc_id)))); // R7

    AST_DUP_NO_FILL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mshr_pending) |=> !(mshr_alloc_valid && mem_req_valid)); // R7

    AST_WB_WITH_ALLOC: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> mshr_alloc_valid); // R5

    AST_ADDR_HAS_TAG: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!mem_req_valid || mem_req_addr[ADDR_W-1 -: TAG_W] == $past(req_tag))); // R10

endmodule

bind set_lookup_lru set_lookup_lru_chk #(
    .PORTS(PORTS), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .MSHR_ID_W(MSHR_ID_W)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_replay      (req_replay),
    .req_tag         (req_tag),
    .req_slot_valid  (req_slot_valid),
    .mshr_pending    (mshr_pending),
    .mshr_alloc_id   (mshr_alloc_id),
    .rsp_valid       (rsp_valid),
    .mem_req_valid   (mem_req_valid),
    .mem_req_addr    (mem_req_addr),
    .mem_req_tag     (mem_req_tag),
    .wb_valid        (wb_valid),
    .mshr_alloc_valid(mshr_alloc_valid)
);

// File: tb/set_lookup_lru_test.sv
`timescale 1ns/1ps
module set_lookup_lru_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       req_valid = 0, req_replay = 0, req_write = 0;
    logic [2:0] req_set = 0;
    logic [7:0] req_tag = 0;
    logic [1:0] req_slot_valid = 0;
    logic [3:0] req_slot_id = 4'b1001;
    logic [7:0] req_slot_tag = 8'hBA;
    logic       inst_valid = 0;
    logic [2:0] inst_set = 0;
    logic [1:0] inst_way = 0;
    logic [7:0] inst_tag = 0;
    logic       mshr_pending = 0;
    logic [1:0] mshr_alloc_id = 0;

    // write-back instance outputs
    logic [1:0] b_rsp_valid; logic [3:0] b_rsp_id; logic [7:0] b_rsp_tag;
    logic b_mem_valid, b_mem_write; logic [15:0] b_mem_addr; logic [1:0] b_mem_tag;
    logic b_wb_valid; logic [15:0] b_wb_addr;
    logic b_al_valid, b_al_write; logic [2:0] b_al_set; logic [7:0] b_al_tag; logic [1:0] b_al_way;
    // write-through instance outputs
    logic [1:0] t_rsp_valid; logic [3:0] t_rsp_id; logic [7:0] t_rsp_tag;
    logic t_mem_valid, t_mem_write; logic [15:0] t_mem_addr; logic [1:0] t_mem_tag;
    logic t_wb_valid; logic [15:0] t_wb_addr;
    logic t_al_valid, t_al_write; logic [2:0] t_al_set; logic [7:0] t_al_tag; logic [1:0] t_al_way;

    set_lookup_lru uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_replay(req_replay),
        .req_write(req_write), .req_set(req_set), .req_tag(req_tag),
        .req_slot_valid(req_slot_valid), .req_slot_id(req_slot_id), .req_slot_tag(req_slot_tag),
        .inst_valid(inst_valid), .inst_set(inst_set), .inst_way(inst_way), .inst_tag(inst_tag),
        .mshr_pending(mshr_pending), .mshr_alloc_id(mshr_alloc_id),
        .rsp_valid(b_rsp_valid), .rsp_id(b_rsp_id), .rsp_tag(b_rsp_tag),
        .mem_req_valid(b_mem_valid), .mem_req_write(b_mem_write), .mem_req_addr(b_mem_addr),
        .mem_req_tag(b_mem_tag), .wb_valid(b_wb_valid), .wb_addr(b_wb_addr),
        .mshr_alloc_valid(b_al_valid), .mshr_alloc_set(b_al_set), .mshr_alloc_tag(b_al_tag),
        .mshr_alloc_way(b_al_way), .mshr_alloc_write(b_al_write)
    );

    set_lookup_lru #(.WRITE_THROUGH(1'b1), .WRITE_RSP(1'b0)) uut_wt (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_replay(req_replay),
        .req_write(req_write), .req_set(req_set), .req_tag(req_tag),
        .req_slot_valid(req_slot_valid), .req_slot_id(req_slot_id), .req_slot_tag(req_slot_tag),
        .inst_valid(inst_valid), .inst_set(inst_set), .inst_way(inst_way), .inst_tag(inst_tag),
        .mshr_pending(mshr_pending), .mshr_alloc_id(mshr_alloc_id),
        .rsp_valid(t_rsp_valid), .rsp_id(t_rsp_id), .rsp_tag(t_rsp_tag),
        .mem_req_valid(t_mem_valid), .mem_req_write(t_mem_write), .mem_req_addr(t_mem_addr),
        .mem_req_tag(t_mem_tag), .wb_valid(t_wb_valid), .wb_addr(t_wb_addr),
        .mshr_alloc_valid(t_al_valid), .mshr_alloc_set(t_al_set), .mshr_alloc_tag(t_al_tag),
        .mshr_alloc_way(t_al_way), .mshr_alloc_write(t_al_write)
    );

    int checks = 0;
    int errors = 0;

    // R10: {tag, set, bank index 1, four zero offset bits}
    function automatic logic [15:0] line(input logic [7:0] t, input logic [2:0] s);
        return {t, s, 1'b1, 4'b0000};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one request; on return its registered results are visible.
    task automatic lookup(input logic rp, input logic wr, input logic [2:0] s,
                          input logic [7:0] t, input logic [1:0] slots,
                          input logic pend, input logic [1:0] id);
        @(negedge clk);
        req_valid = 1; req_replay = rp; req_write = wr; req_set = s; req_tag = t;
        req_slot_valid = slots; mshr_pending = pend; mshr_alloc_id = id;
        @(negedge clk);
        req_valid = 0; req_replay = 0; req_write = 0; mshr_pending = 0;
    endtask

    task automatic install(input logic [2:0] s, input logic [1:0] w, input logic [7:0] t);
        @(negedge clk);
        inst_valid = 1; inst_set = s; inst_way = w; inst_tag = t;
        @(negedge clk);
        inst_valid = 0;
    endtask

    task automatic fill_set(input logic [2:0] s, input logic [7:0] base);
        for (int w = 0; w < 4; w++) install(s, 2'(w), base + 8'(w));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "rsp_valid", 32'(b_rsp_valid), 0);
        check("R1", "mem_req_valid", 32'(b_mem_valid), 0);
        check("R12", "idle alloc/wb", 32'({b_al_valid, b_wb_valid}), 0);
    endtask

    task automatic t_cold_miss();
        lookup(0, 0, 3'd0, 8'h05, 2'b01, 0, 2'd2);
        check("R1", "cold miss no rsp", 32'(b_rsp_valid), 0);
        check("R7", "alloc valid", 32'(b_al_valid), 1);
        check("R3", "victim highest invalid", 32'(b_al_way), 3);
        check("R7", "fill valid/write", 32'({b_mem_valid, b_mem_write}), 32'b10);
        check("R7", "fill tag = id", 32'(b_mem_tag), 2);
        check("R10", "fill addr", 32'(b_mem_addr), 32'(line(8'h05, 3'd0)));
        lookup(0, 0, 3'd0, 8'h05, 2'b01, 1, 2'd1);
        check("R7", "dup miss alloc", 32'(b_al_valid), 1);
        check("R7", "dup miss no fill", 32'(b_mem_valid), 0);
    endtask

    task automatic t_hit_lru();
        fill_set(3'd1, 8'h10);
        lookup(0, 0, 3'd1, 8'h11, 2'b11, 0, 2'd0);
        check("R4", "hit rsp_valid", 32'(b_rsp_valid), 32'b11);
        check("R4", "hit rsp_id", 32'(b_rsp_id), 32'h9);
        check("R4", "hit rsp_tag", 32'(b_rsp_tag), 32'hBA);
        check("R4", "hit no mem/alloc", 32'({b_mem_valid, b_al_valid}), 0);
        lookup(0, 0, 3'd1, 8'h10, 2'b01, 0, 2'd0);
        lookup(0, 0, 3'd1, 8'h12, 2'b01, 0, 2'd0);
        lookup(0, 0, 3'd1, 8'h20, 2'b01, 0, 2'd1);
        check("R2", "lru victim set1", 32'(b_al_way), 1);
        check("R5", "clean victim no wb", 32'(b_wb_valid), 0);
    endtask

    task automatic t_saturate();
        fill_set(3'd2, 8'h20);
        for (int i = 0; i < 3; i++) lookup(0, 0, 3'd2, 8'h23, 2'b01, 0, 2'd0);
        lookup(0, 0, 3'd2, 8'h20, 2'b01, 0, 2'd0);
        lookup(0, 0, 3'd2, 8'h29, 2'b01, 0, 2'd0);
        check("R2", "saturated age victim", 32'(b_al_way), 1);
    endtask

    task automatic t_invalid_pref();
        install(3'd3, 2'd0, 8'h30); install(3'd3, 2'd2, 8'h32);
        lookup(0, 0, 3'd3, 8'h3F, 2'b01, 0, 2'd0);
        check("R3", "invalid way 3 preferred", 32'(b_al_way), 3);
        install(3'd4, 2'd0, 8'h40); install(3'd4, 2'd1, 8'h41); install(3'd4, 2'd3, 8'h43);
        lookup(0, 0, 3'd4, 8'h4F, 2'b01, 0, 2'd0);
        check("R3", "invalid way 2 preferred", 32'(b_al_way), 2);
    endtask

    task automatic t_writeback();
        fill_set(3'd5, 8'h30);
        lookup(0, 1, 3'd5, 8'h30, 2'b01, 0, 2'd0);
        check("R6", "write hit rsp", 32'(b_rsp_valid), 32'b01);
        check("R6", "write hit no mem", 32'({b_mem_valid, b_wb_valid, b_al_valid}), 0);
        for (int i = 1; i < 4; i++) lookup(0, 0, 3'd5, 8'h30 + 8'(i), 2'b01, 0, 2'd0);
        lookup(0, 0, 3'd5, 8'h40, 2'b01, 0, 2'd3);
        check("R5", "dirty victim wb", 32'(b_wb_valid), 1);
        check("R5", "wb addr", 32'(b_wb_addr), 32'(line(8'h30, 3'd5)));
        check("R7", "alloc way 0", 32'(b_al_way), 0);
        check("R7", "fill tag", 32'(b_mem_tag), 3);
        // R11: reinstall cleans the way and zeroes its age
        install(3'd5, 2'd0, 8'h50);
        for (int i = 1; i < 4; i++) lookup(0, 0, 3'd5, 8'h30 + 8'(i), 2'b01, 0, 2'd0);
        lookup(0, 0, 3'd5, 8'h41, 2'b01, 0, 2'd0);
        check("R11", "reinstalled way victim", 32'(b_al_way), 0);
        check("R11", "reinstalled way clean", 32'(b_wb_valid), 0);
    endtask

    task automatic t_replay();
        fill_set(3'd6, 8'h60);
        lookup(1, 0, 3'd6, 8'h60, 2'b11, 0, 2'd0);
        check("R8", "replay rsp", 32'(b_rsp_valid), 32'b11);
        check("R8", "replay no mem", 32'({b_mem_valid, b_wb_valid, b_al_valid}), 0);
        lookup(0, 0, 3'd6, 8'h69, 2'b01, 0, 2'd0);
        check("R8", "replay left ages", 32'(b_al_way), 0);
    endtask

    task automatic t_write_through();
        install(3'd7, 2'd0, 8'h70);
        lookup(0, 1, 3'd7, 8'h70, 2'b01, 0, 2'd2);
        check("R9", "wt hit fwd", 32'({t_mem_valid, t_mem_write}), 32'b11);
        check("R9", "wt hit addr", 32'(t_mem_addr), 32'(line(8'h70, 3'd7)));
        check("R9", "wt hit tag 0", 32'(t_mem_tag), 0);
        check("R9", "wt hit no rsp/alloc", 32'({t_rsp_valid, t_al_valid}), 0);
        lookup(0, 1, 3'd7, 8'h71, 2'b01, 0, 2'd2);
        check("R9", "wt miss fwd", 32'({t_mem_valid, t_mem_write}), 32'b11);
        check("R9", "wt miss addr", 32'(t_mem_addr), 32'(line(8'h71, 3'd7)));
        check("R9", "wt miss no alloc/rsp", 32'({t_rsp_valid, t_al_valid}), 0);
        lookup(0, 0, 3'd7, 8'h70, 2'b11, 0, 2'd0);
        check("R4", "wt read hit rsp", 32'(t_rsp_valid), 32'b11);
        lookup(0, 0, 3'd7, 8'h72, 2'b01, 0, 2'd1);
        check("R9", "wt read miss alloc", 32'({t_al_valid, t_al_way}), 32'b111);
        check("R9", "wt read miss fill", 32'({t_mem_valid, t_mem_write, t_mem_tag}), 32'b1001);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_cold_miss();
        t_hit_lru();
        t_saturate();
        t_invalid_pref();
        t_writeback();
        t_replay();
        t_write_through();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule